// File: doc/BRIEF.md
# Single-Wire Bus Bit Responder

This block is the bit-level engine of a slave device on an open-drain single-wire bus. It watches the already synchronized bus level and measures how long each low lasts, using a one-microsecond clock-enable tick. It drives the bus only by pulling it low, through a drive-enable output. A low that lasts long enough is a bus reset. The block answers it, once the bus has gone high again, with a presence pulse. Any shorter low starts a time slot.

A single timing point, counted from the falling edge, governs each slot. In a write slot the block samples the bus at that point and hands the bit to the user logic. In a read slot it holds the bus low until that point to send a zero, or leaves the bus alone to send a one. A mode input chosen before the slot starts decides whether the slot is a read or a write.

Data leaves the block through a valid-only stream and enters it through a valid/ready stream. The bus cannot wait, so the receive stream has no back-pressure. The sink must take `rx_data` in the single cycle in which `rx_valid` is high. On the transmit side, the user places a bit on `tx_data` with `tx_valid` before the slot begins. The block takes it in the cycle where `tx_ready` is high, which is the falling edge that opens a read slot. If `tx_valid` is low in that cycle, the slot sends a one.

Top module: `swb_slave`

## Requirements
- R1: After reset, `line_drive`, `rx_valid`, `tx_ready` and `bus_reset` are all 0.
- R2: In a write slot (`rd_mode`=0 at the falling edge), the bus is sampled on the SAMPLE_US-th tick after the falling edge (30 by default). `rx_data` carries the sampled level (1 = bus high) and `rx_valid` is high for exactly one cycle. A low that ends by 25 µs yields 1, and a low that lasts to 35 µs or longer yields 0.
- R3: In a read slot with `tx_valid`=1 and `tx_data`=0, `line_drive` is 1 from the falling edge until the SAMPLE_US-th tick, then 0. No `rx_valid` is produced.
- R4: In a read slot with `tx_data`=1, or with `tx_valid`=0, `line_drive` stays 0 for the whole slot.
- R5: `tx_ready` is high for one cycle on the falling edge that opens a read slot, and never in a write slot.
- R6: A low lasting RESET_US ticks (480 by default) raises `bus_reset` for one cycle. This holds whatever slot is in progress, including a read slot sending zero.
- R7: A low shorter than RESET_US ticks (for example 470 µs) raises no `bus_reset` and is treated as a write slot, which delivers a 0.
- R8: After a detected reset, once the bus goes high, the block waits PWAIT_US ticks (30) without driving. It then drives `line_drive` high for PLOW_US ticks (120) and releases.
- R9: The falling edge caused by the block's own presence pulse opens no slot. No `tx_ready`, no `rx_valid` and no read-zero drive follow it.
- R10: From reset detection until the presence phase begins, `line_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Synchronized bus level (1 = high) |
| rd_mode | input | 1 | 1: next slot is a read slot, 0: a write slot |
| tx_valid | input | 1 | Transmit bit is valid |
| tx_data | input | 1 | Bit to send in the next read slot |
| tx_ready | output | 1 | Transmit bit taken this cycle |
| rx_valid | output | 1 | One-cycle strobe, write bit sampled |
| rx_data | output | 1 | Sampled write bit |
| line_drive | output | 1 | 1 pulls the bus low |
| bus_reset | output | 1 | One-cycle pulse on reset detection |

## Verification
The bench drives lows that end 5 µs on either side of the sample point. A design that samples early or late decodes those write bits wrongly. It uses a 470 µs low against a 500 µs low to catch an off-by-margin reset threshold, which would either miss real resets or cut ordinary long slots short. The presence pulse is probed inside its wait, inside its low phase and after it. A design that treats its own presence edge as a slot start would pulse `tx_ready` or stretch the bus low afterwards. A read slot with no valid transmit bit must leave the bus untouched.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_DONE,
    ST_RST,
    ST_PWAIT,
    ST_PLOW
  } swb_state_e;
endpackage

// File: rtl/swb_line_monitor.sv
module swb_line_monitor #(
  parameter int RESET_US = 480,
  parameter int CW = $clog2(RESET_US + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic fall,
  output logic long_low
);
  localparam logic [CW-1:0] LOW_LIMIT = CW'(RESET_US);

  logic          line_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      line_q <= line_in;
      if (line_in)
        low_cnt <= '0;
      else if (tick && low_cnt != LOW_LIMIT)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign fall     = line_q & ~line_in;
  assign long_low = (low_cnt == LOW_LIMIT);

  // R6: the reset threshold is only reached while the bus was low
  p_long_low_from_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_low) |-> $past(!line_in));
endmodule

// File: rtl/swb_slot_engine.sv
module swb_slot_engine
  import swb_pkg::*;
#(
  parameter int SAMPLE_US = 30,
  parameter int PWAIT_US  = 30,
  parameter int PLOW_US   = 120,
  parameter int PW        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  input  logic fall,
  input  logic long_low,
  input  logic rd_mode,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  output logic rx_valid,
  output logic rx_data,
  output logic line_drive,
  output logic bus_reset
);
  localparam logic [PW-1:0] SAMPLE_END = PW'(SAMPLE_US - 1);
  localparam logic [PW-1:0] PWAIT_END  = PW'(PWAIT_US - 1);
  localparam logic [PW-1:0] PLOW_END   = PW'(PLOW_US - 1);

  swb_state_e    state;
  logic [PW-1:0] ph_cnt;
  logic          is_read;
  logic          reset_go;

  assign reset_go = long_low && state != ST_RST && state != ST_PLOW;
  assign tx_ready = (state == ST_IDLE) && fall && rd_mode && !reset_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ph_cnt     <= '0;
      is_read    <= 1'b0;
      line_drive <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= 1'b0;
      bus_reset  <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      bus_reset <= 1'b0;
      if (reset_go) begin
        state      <= ST_RST;
        line_drive <= 1'b0;
        bus_reset  <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (fall) begin
            state      <= ST_SLOT;
            ph_cnt     <= '0;
            is_read    <= rd_mode;
            line_drive <= rd_mode & tx_valid & ~tx_data;
          end
          ST_SLOT: if (tick) begin
            if (ph_cnt == SAMPLE_END) begin
              if (!is_read) begin
                rx_valid <= 1'b1;
                rx_data  <= line_in;
              end
              line_drive <= 1'b0;
              state      <= ST_DONE;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          ST_DONE: if (line_in) state <= ST_IDLE;
          ST_RST: if (line_in) begin
            state  <= ST_PWAIT;
            ph_cnt <= '0;
          end
          ST_PWAIT: if (tick) begin
            if (ph_cnt == PWAIT_END) begin
              state      <= ST_PLOW;
              ph_cnt     <= '0;
              line_drive <= 1'b1;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          ST_PLOW: if (tick) begin
            if (ph_cnt == PLOW_END) begin
              state      <= ST_IDLE;
              line_drive <= 1'b0;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: one strobe per write sample
  p_rx_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R2: a sample is never taken while this block pulls the bus
  p_rx_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !line_drive);
  // R4: a read slot without a valid bit leaves the bus alone
  p_no_bit_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !line_drive);
  // R5: transmit handshake lasts one cycle
  p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
  // R10: released when the reset is reported and through the wait
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || state == ST_PWAIT) |-> !line_drive);
endmodule

// File: rtl/swb_slave.sv
module swb_slave #(
  parameter int SAMPLE_US = 30,
  parameter int RESET_US  = 480,
  parameter int PWAIT_US  = 30,
  parameter int PLOW_US   = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic line_in,
  input  logic rd_mode,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  output logic rx_valid,
  output logic rx_data,
  output logic line_drive,
  output logic bus_reset
);
  localparam int CW    = $clog2(RESET_US + 1);
  localparam int MAXP0 = (SAMPLE_US > PWAIT_US) ? SAMPLE_US : PWAIT_US;
  localparam int MAXP  = (MAXP0 > PLOW_US) ? MAXP0 : PLOW_US;
  localparam int PW    = $clog2(MAXP + 1);

  logic fall;
  logic long_low;

  swb_line_monitor #(.RESET_US(RESET_US), .CW(CW)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .line_in  (line_in),
    .fall     (fall),
    .long_low (long_low)
  );

  swb_slot_engine #(
    .SAMPLE_US (SAMPLE_US),
    .PWAIT_US  (PWAIT_US),
    .PLOW_US   (PLOW_US),
    .PW        (PW)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_us),
    .line_in    (line_in),
    .fall       (fall),
    .long_low   (long_low),
    .rd_mode    (rd_mode),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .line_drive (line_drive),
    .bus_reset  (bus_reset)
  );
endmodule

// File: tb/swb_slave_test.sv
module swb_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic m_low = 1'b0;
  logic rd_mode = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_data = 1'b0;
  logic tx_ready, rx_valid, rx_data, line_drive, bus_reset;
  logic line;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0, tx_cnt = 0, rst_cnt = 0;
  logic rx_last = 1'b0;
  logic drive_seen = 1'b0;
  int div = 0;

  always #5 clk = ~clk;

  assign line = !(m_low || line_drive);

  swb_slave uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .line_in(line),
    .rd_mode(rd_mode), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .line_drive(line_drive), .bus_reset(bus_reset)
  );

  always @(posedge clk) begin
    div  <= (div == 4) ? 0 : div + 1;
    tick <= (div == 4);
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (tx_ready) tx_cnt <= tx_cnt + 1;
    if (bus_reset) rst_cnt <= rst_cnt + 1;
    if (line_drive) drive_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  task automatic slot(input int low_us, input int total_us);
    @(negedge clk);
    m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0;
    wait_us(total_us - low_us);
  endtask

  task automatic t_reset_state;
    chk(line_drive == 0, "R1 line_drive", line_drive, 0);
    chk(rx_valid == 0 && tx_ready == 0 && bus_reset == 0, "R1 strobes",
        {rx_valid, tx_ready, bus_reset}, 0);
  endtask

  task automatic t_write;
    int r0, t0;
    rd_mode = 1'b0; r0 = rx_cnt; t0 = tx_cnt;
    slot(5, 70);
    chk(rx_cnt == r0 + 1 && rx_last == 1, "R2 write one", rx_last, 1);
    slot(60, 70);
    chk(rx_cnt == r0 + 2 && rx_last == 0, "R2 write zero", rx_last, 0);
    slot(25, 70);
    chk(rx_last == 1, "R2 low ends 25us", rx_last, 1);
    slot(35, 70);
    chk(rx_last == 0, "R2 low to 35us", rx_last, 0);
    chk(rx_cnt == r0 + 4, "R2 one strobe per slot", rx_cnt - r0, 4);
    chk(tx_cnt == t0, "R5 no ready in write slot", tx_cnt - t0, 0);
  endtask

  task automatic t_read_zero;
    int r0, t0;
    rd_mode = 1'b1; tx_valid = 1'b1; tx_data = 1'b0; r0 = rx_cnt; t0 = tx_cnt;
    @(negedge clk);
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    chk(tx_cnt == t0 + 1, "R5 ready on read edge", tx_cnt - t0, 1);
    wait_us(18);
    chk(line_drive == 1 && line == 0, "R3 hold low at 20us", line_drive, 1);
    wait_us(20);
    chk(line_drive == 0 && line == 1, "R3 released at 40us", line_drive, 0);
    wait_us(30);
    chk(rx_cnt == r0, "R3 no rx in read slot", rx_cnt - r0, 0);
  endtask

  task automatic t_read_one;
    int t0;
    rd_mode = 1'b1; tx_valid = 1'b1; tx_data = 1'b1; t0 = tx_cnt;
    @(negedge clk); drive_seen = 1'b0;
    slot(2, 70);
    chk(drive_seen == 0, "R4 read one undriven", drive_seen, 0);
    tx_valid = 1'b0; tx_data = 1'b0;
    @(negedge clk); drive_seen = 1'b0;
    slot(2, 70);
    chk(drive_seen == 0, "R4 no valid bit undriven", drive_seen, 0);
    chk(tx_cnt == t0 + 2, "R5 ready each read slot", tx_cnt - t0, 2);
  endtask

  task automatic presence_check(input string tag);
    @(negedge clk);
    m_low = 1'b0;
    wait_us(20);
    chk(line_drive == 0, {tag, " R10 quiet in wait"}, line_drive, 0);
    wait_us(25);
    chk(line_drive == 1, {tag, " R8 presence at 45us"}, line_drive, 1);
    wait_us(95);
    chk(line_drive == 1, {tag, " R8 presence at 140us"}, line_drive, 1);
    wait_us(25);
    chk(line_drive == 0, {tag, " R8 released at 165us"}, line_drive, 0);
  endtask

  task automatic t_reset_presence;
    int b0, r0;
    rd_mode = 1'b0; b0 = rst_cnt; r0 = rx_cnt;
    @(negedge clk);
    m_low = 1'b1;
    wait_us(500);
    chk(rst_cnt == b0 + 1, "R6 reset pulse", rst_cnt - b0, 1);
    chk(line_drive == 0, "R10 no drive in reset low", line_drive, 0);
    presence_check("plain");
    chk(rx_cnt == r0 + 1, "R9 no rx from presence edge", rx_cnt - r0, 1);
  endtask

  task automatic t_reset_in_read;
    int b0, t0;
    rd_mode = 1'b1; tx_valid = 1'b1; tx_data = 1'b0; b0 = rst_cnt;
    @(negedge clk);
    m_low = 1'b1;
    wait_us(10);
    chk(line_drive == 1, "R3 driving before reset", line_drive, 1);
    wait_us(490);
    chk(rst_cnt == b0 + 1, "R6 reset during read slot", rst_cnt - b0, 1);
    t0 = tx_cnt;
    presence_check("read");
    wait_us(40);
    chk(tx_cnt == t0, "R9 no ready from presence edge", tx_cnt - t0, 0);
    chk(line_drive == 0, "R9 no read drive after presence", line_drive, 0);
    tx_valid = 1'b0;
  endtask

  task automatic t_short_low;
    int b0, r0;
    rd_mode = 1'b0; b0 = rst_cnt; r0 = rx_cnt;
    @(negedge clk); drive_seen = 1'b0;
    slot(470, 480);
    wait_us(100);
    chk(rst_cnt == b0, "R7 no reset at 470us", rst_cnt - b0, 0);
    chk(rx_cnt == r0 + 1 && rx_last == 0, "R7 treated as write zero", rx_last, 0);
    chk(drive_seen == 0, "R7 no presence", drive_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    wait_us(5);
    t_reset_state();
    t_write();
    t_read_zero();
    t_read_one();
    t_reset_presence();
    t_reset_in_read();
    t_short_low();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule